// File: doc/BRIEF.md
# Doorbell Signal Router

This block passes doorbell signals between processors on a chip. The local processor names every signal by a 32-bit identifier that packs a client number and a signal number. Writing an identifier to the send register raises that signal at the named client. Remote clients raise signals toward the local processor through an inbound strobe port.

For every incoming (client, signal) pair the block holds a pending bit and an enable bit. One active-high level interrupt summarises all enabled pending signals. Software services the interrupt in a loop. It reads the receive register to get the identifier of one pending enabled signal, then writes that identifier to the clear register. It repeats until the receive register returns all-ones.

Enable, disable, single clear and whole-client clear all take a packed identifier through their own write-only registers. A send addressed to the local client loops back into the local pending array.

Top module: `doorbell_router`

## Requirements
- R1: An identifier carries the client number in bits 31:16 and the signal number in bits 15:0. A send, enable, disable or clear whose client is not below NUM_CLIENTS, or whose signal is not below NUM_SIGNALS, changes nothing. A write to an offset not listed in R2, R4, R5 or R6 changes nothing.
- R2: A write to offset 0x0C with an in-range identifier whose client is not LOCAL_CLIENT sets sendValid for exactly the cycle after the write, with sendClient and sendSignal taken from the identifier. If the client is LOCAL_CLIENT, sendValid stays low and the pair (LOCAL_CLIENT, signal) becomes pending.
- R3: A read from offset 0x10 returns, on busRdata, the identifier of the pending enabled signal with the lowest client number, and within that client the lowest signal number. It returns 0xFFFFFFFF when no enabled signal is pending. Read data and rdValid appear in the cycle after the read request. Reads of any other offset return zero.
- R4: A write to offset 0x14 enables a pair and a write to offset 0x18 disables it. A disabled pair may still become pending. While disabled it is hidden from the receive register and from the interrupt, and it keeps its pending state.
- R5: A write to offset 0x1C clears the pending bit of the named pair.
- R6: A write to offset 0x38 clears the pending bits of every signal of the client held in bits 31:16. Other clients keep their pending bits.
- R7: irqOut is high exactly while at least one enabled pair is pending.
- R8: An inbound strobe with an in-range client and signal makes that pair pending on the next clock edge. When it falls in the same cycle as a clear of the same pair, the pair stays pending.
- R9: Reset clears every pending bit and every enable bit, and drives sendValid, rdValid and irqOut low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| inValid | input | 1 | Inbound signal strobe from a remote client |
| inClient | input | 16 | Source client of the inbound signal |
| inSignal | input | 16 | Signal number of the inbound signal |
| sendValid | output | 1 | Outbound doorbell strobe |
| sendClient | output | 16 | Destination client of the outbound doorbell |
| sendSignal | output | 16 | Signal number of the outbound doorbell |
| irqOut | output | 1 | Level summary interrupt |

## Verification
The two functions that can meet in one cycle are a pending set and a pending clear of the same pair. The set comes from the inbound strobe and the clear comes from a bus write to the clear register. The bench provokes the meeting by raising the inbound strobe on the very clock edge at which a clear of the same identifier is written. It then judges the result by reading the receive register, which must still return that identifier, and by checking that irqOut is still high. The same-cycle pairing of an inbound set with a whole-client clear is covered by an assertion, which requires the inbound pair to be pending in the next cycle.

// File: rtl/doorbell_router_pkg.sv
package doorbell_router_pkg;

  // register offsets (byte addresses)
  localparam int OFF_SEND    = 'h0C;
  localparam int OFF_RECV    = 'h10;
  localparam int OFF_ENABLE  = 'h14;
  localparam int OFF_DISABLE = 'h18;
  localparam int OFF_CLEAR   = 'h1C;
  localparam int OFF_CLI_CLR = 'h38;

  localparam logic [31:0] NONE_PENDING = 32'hFFFF_FFFF;

  // strobes from control to datapath, range already checked
  typedef struct packed {
    logic        loopSet;
    logic        setEn;
    logic        setDis;
    logic        clrOne;
    logic        clrClient;
    logic [15:0] client;
    logic [15:0] signal;
  } dpStrobe_t;

endpackage

// File: rtl/doorbell_router_ctrl.sv
module doorbell_router_ctrl
  import doorbell_router_pkg::*;
#(
  parameter int NUM_CLIENTS  = 4,
  parameter int NUM_SIGNALS  = 8,
  parameter int LOCAL_CLIENT = 1,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       recvId,
  output dpStrobe_t         stb,
  output logic [31:0]       busRdata,
  output logic              rdValid,
  output logic              sendValid,
  output logic [15:0]       sendClient,
  output logic [15:0]       sendSignal
);

  localparam logic [15:0] NC16    = 16'(NUM_CLIENTS);
  localparam logic [15:0] NS16    = 16'(NUM_SIGNALS);
  localparam logic [15:0] LOCAL16 = 16'(LOCAL_CLIENT);

  logic [15:0] wrClient;
  logic [15:0] wrSignal;
  logic        clientOk;
  logic        idOk;
  logic        wrEv;
  logic        isLocal;

  assign wrClient = busWdata[31:16];
  assign wrSignal = busWdata[15:0];
  assign clientOk = wrClient < NC16;
  assign idOk     = clientOk && (wrSignal < NS16);
  assign wrEv     = busSel && busWr;
  assign isLocal  = wrClient == LOCAL16;

  always_comb begin
    stb           = '0;
    stb.client    = wrClient;
    stb.signal    = wrSignal;
    stb.loopSet   = wrEv && (busAddr == ADDR_W'(OFF_SEND)) && idOk && isLocal;
    stb.setEn     = wrEv && (busAddr == ADDR_W'(OFF_ENABLE)) && idOk;
    stb.setDis    = wrEv && (busAddr == ADDR_W'(OFF_DISABLE)) && idOk;
    stb.clrOne    = wrEv && (busAddr == ADDR_W'(OFF_CLEAR)) && idOk;
    stb.clrClient = wrEv && (busAddr == ADDR_W'(OFF_CLI_CLR)) && clientOk;
  end

  // outbound doorbell, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendValid  <= 1'b0;
      sendClient <= '0;
      sendSignal <= '0;
    end else begin
      sendValid <= wrEv && (busAddr == ADDR_W'(OFF_SEND)) && idOk && !isLocal;
      if (wrEv && (busAddr == ADDR_W'(OFF_SEND))) begin
        sendClient <= wrClient;
        sendSignal <= wrSignal;
      end
    end
  end

  // one-cycle read path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      busRdata <= '0;
    end else begin
      rdValid <= busSel && !busWr;
      if (busSel && !busWr)
        busRdata <= (busAddr == ADDR_W'(OFF_RECV)) ? recvId : 32'd0;
    end
  end

endmodule

// File: rtl/doorbell_router_dp.sv
module doorbell_router_dp
  import doorbell_router_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  localparam int TOTAL      = NUM_CLIENTS * NUM_SIGNALS,
  localparam int IW         = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             inValid,
  input  logic [15:0]      inClient,
  input  logic [15:0]      inSignal,
  output logic [TOTAL-1:0] pendVec,
  output logic [TOTAL-1:0] enVec,
  output logic [31:0]      recvId,
  output logic             irqOut
);

  function automatic logic [IW-1:0] flatIdx(logic [15:0] c, logic [15:0] s);
    return IW'(c * 16'(NUM_SIGNALS) + s);
  endfunction

  logic [TOTAL-1:0] setVec;
  logic [TOTAL-1:0] clrVec;
  logic [TOTAL-1:0] hitVec;
  logic             inOk;

  assign inOk = inValid && (inClient < 16'(NUM_CLIENTS)) && (inSignal < 16'(NUM_SIGNALS));

  always_comb begin
    setVec = '0;
    if (inOk)        setVec[flatIdx(inClient, inSignal)] = 1'b1;
    if (stb.loopSet) setVec[flatIdx(stb.client, stb.signal)] = 1'b1;
  end

  always_comb begin
    clrVec = '0;
    if (stb.clrOne) clrVec[flatIdx(stb.client, stb.signal)] = 1'b1;
    if (stb.clrClient)
      for (int s = 0; s < NUM_SIGNALS; s++)
        clrVec[flatIdx(stb.client, 16'(s))] = 1'b1;
  end

  // set is applied after clear so a coincident arrival is never lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendVec <= '0;
    else       pendVec <= (pendVec & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enVec <= '0;
    else if (stb.setEn)  enVec[flatIdx(stb.client, stb.signal)] <= 1'b1;
    else if (stb.setDis) enVec[flatIdx(stb.client, stb.signal)] <= 1'b0;
  end

  assign hitVec = pendVec & enVec;
  assign irqOut = |hitVec;

  // lowest flat index wins: lowest client, then lowest signal
  always_comb begin
    recvId = NONE_PENDING;
    for (int i = TOTAL - 1; i >= 0; i--)
      if (hitVec[i]) recvId = {16'(i / NUM_SIGNALS), 16'(i % NUM_SIGNALS)};
  end

endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
  import doorbell_router_pkg::*;
#(
  parameter int NUM_CLIENTS  = 4,
  parameter int NUM_SIGNALS  = 8,
  parameter int LOCAL_CLIENT = 1,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rdValid,
  input  logic              inValid,
  input  logic [15:0]       inClient,
  input  logic [15:0]       inSignal,
  output logic              sendValid,
  output logic [15:0]       sendClient,
  output logic [15:0]       sendSignal,
  output logic              irqOut
);

  localparam int TOTAL = NUM_CLIENTS * NUM_SIGNALS;

  dpStrobe_t        stb;
  logic [31:0]      recvId;
  logic [TOTAL-1:0] pendVec;
  logic [TOTAL-1:0] enVec;

  doorbell_router_ctrl #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .NUM_SIGNALS (NUM_SIGNALS),
    .LOCAL_CLIENT(LOCAL_CLIENT),
    .ADDR_W      (ADDR_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .recvId    (recvId),
    .stb       (stb),
    .busRdata  (busRdata),
    .rdValid   (rdValid),
    .sendValid (sendValid),
    .sendClient(sendClient),
    .sendSignal(sendSignal)
  );

  doorbell_router_dp #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .NUM_SIGNALS(NUM_SIGNALS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inValid (inValid),
    .inClient(inClient),
    .inSignal(inSignal),
    .pendVec (pendVec),
    .enVec   (enVec),
    .recvId  (recvId),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/doorbell_router_chk.sv
module doorbell_router_chk #(
  parameter int NUM_CLIENTS  = 4,
  parameter int NUM_SIGNALS  = 8,
  parameter int LOCAL_CLIENT = 1,
  parameter int ADDR_W       = 8,
  localparam int TOTAL       = NUM_CLIENTS * NUM_SIGNALS,
  localparam int IW          = $clog2(TOTAL)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              inValid,
  input logic [15:0]       inClient,
  input logic [15:0]       inSignal,
  input logic [TOTAL-1:0]  pendVec,
  input logic [TOTAL-1:0]  enVec,
  input logic [31:0]       recvId,
  input logic              irqOut,
  input logic              rdValid,
  input logic              sendValid,
  input logic [15:0]       sendClient
);

  function automatic logic [IW-1:0] toIdx(logic [15:0] c, logic [15:0] s);
    return IW'(c * 16'(NUM_SIGNALS) + s);
  endfunction

  logic          inOk;
  logic          wrOk;
  logic [IW-1:0] inIdx;
  logic [IW-1:0] wrIdx;
  logic [IW-1:0] rxIdx;

  assign inOk  = inValid && (inClient < 16'(NUM_CLIENTS)) && (inSignal < 16'(NUM_SIGNALS));
  assign wrOk  = busSel && busWr && (busWdata[31:16] < 16'(NUM_CLIENTS))
                 && (busWdata[15:0] < 16'(NUM_SIGNALS));
  assign inIdx = toIdx(inClient, inSignal);
  assign wrIdx = toIdx(busWdata[31:16], busWdata[15:0]);
  assign rxIdx = toIdx(recvId[31:16], recvId[15:0]);

  AST_IRQ_MATCHES_RECV: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (recvId != 32'hFFFF_FFFF)); // R7

  AST_RECV_IS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (recvId != 32'hFFFF_FFFF) |-> (pendVec[rxIdx] && enVec[rxIdx])); // R3

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr) |=> rdValid); // R3

  AST_INBOUND_SETS: assert property (@(posedge clk) disable iff (!rstN)
    inOk |=> pendVec[$past(inIdx)]); // R8

  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && (busAddr == ADDR_W'('h1C)) && !(inOk && inIdx == wrIdx))
      |=> !pendVec[$past(wrIdx)]); // R5

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && (busAddr == ADDR_W'('h14))) |=> enVec[$past(wrIdx)]); // R4

  AST_SEND_REMOTE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    sendValid |-> ((sendClient < 16'(NUM_CLIENTS)) && (sendClient != 16'(LOCAL_CLIENT)))); // R2

endmodule

bind doorbell_router doorbell_router_chk #(
  .NUM_CLIENTS (NUM_CLIENTS),
  .NUM_SIGNALS (NUM_SIGNALS),
  .LOCAL_CLIENT(LOCAL_CLIENT),
  .ADDR_W      (ADDR_W)
) chk_i (.*);

// File: tb/doorbell_router_tb_top.sv
module doorbell_router_tb_top;

  localparam int NC = 4;
  localparam int NS = 8;
  localparam int LC = 1;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          rdValid;
  logic          inValid = 1'b0;
  logic [15:0]   inClient = '0;
  logic [15:0]   inSignal = '0;
  logic          sendValid;
  logic [15:0]   sendClient;
  logic [15:0]   sendSignal;
  logic          irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  doorbell_router #(
    .NUM_CLIENTS(NC), .NUM_SIGNALS(NS), .LOCAL_CLIENT(LC), .ADDR_W(AW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rdValid(rdValid),
    .inValid(inValid), .inClient(inClient), .inSignal(inSignal),
    .sendValid(sendValid), .sendClient(sendClient), .sendSignal(sendSignal),
    .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every read response is popped and compared
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R3 unexpected read data", 32'd1, 32'd0);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = AW'(addr); busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = AW'(addr);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic inbound(int c, int s);
    @(negedge clk);
    inValid = 1'b1; inClient = 16'(c); inSignal = 16'(s);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] id(int c, int s);
    return {16'(c), 16'(s)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 irq after reset", 32'(irqOut), 0);
    check("R9 sendValid after reset", 32'(sendValid), 0);
    check("R9 rdValid after reset", 32'(rdValid), 0);
    busRead('h10, 32'hFFFF_FFFF, "R3 empty receive after reset");

    // disabled pending is hidden
    inbound(2, 3);
    check("R4 disabled pending irq", 32'(irqOut), 0);
    busRead('h10, 32'hFFFF_FFFF, "R4 disabled pending hidden");
    busWrite('h14, id(2, 3));
    check("R7 irq after enable", 32'(irqOut), 1);
    busRead('h10, id(2, 3), "R4 enable reveals pending");

    // ordering: client 0 before 1 before 2
    inbound(0, 5);
    busWrite('h14, id(0, 5));
    busWrite('h14, id(1, 1));
    busWrite('h0C, id(1, 1));
    check("R2 local send no strobe", 32'(sendValid), 0);
    busRead('h10, id(0, 5), "R3 lowest client first");
    busWrite('h1C, id(0, 5));
    busRead('h10, id(1, 1), "R2 loopback pending");
    busWrite('h1C, id(1, 1));
    busRead('h10, id(2, 3), "R5 advance after clear");
    busWrite('h1C, id(2, 3));
    busRead('h10, 32'hFFFF_FFFF, "R5 drained");
    check("R7 irq low after drain", 32'(irqOut), 0);

    // lowest signal within a client
    busWrite('h14, id(3, 6));
    busWrite('h14, id(3, 2));
    inbound(3, 6);
    inbound(3, 2);
    busRead('h10, id(3, 2), "R3 lowest signal first");
    busRead('h14, 32'd0, "R3 other offset reads zero");

    // client clear keeps other clients
    busWrite('h14, id(2, 1));
    inbound(2, 1);
    inbound(0, 5);
    busWrite('h38, id(3, 0));
    busRead('h10, id(0, 5), "R6 client clear");
    busWrite('h1C, id(0, 5));
    busRead('h10, id(2, 1), "R6 other client kept");
    busWrite('h38, id(2, 0));
    busRead('h10, 32'hFFFF_FFFF, "R6 client 2 cleared");

    // remote send strobe
    busWrite('h0C, id(3, 7));
    check("R2 remote send valid", 32'(sendValid), 1);
    check("R2 remote send client", 32'(sendClient), 3);
    check("R2 remote send signal", 32'(sendSignal), 7);
    @(negedge clk);
    check("R2 send one cycle", 32'(sendValid), 0);

    // out-of-range identifiers
    busWrite('h0C, id(4, 0));
    check("R1 out-of-range client send", 32'(sendValid), 0);
    busWrite('h14, id(2, 0));
    busWrite('h0C, id(1, 8));
    busRead('h10, 32'hFFFF_FFFF, "R1 out-of-range signal ignored");
    inbound(1, 9);
    busRead('h10, 32'hFFFF_FFFF, "R1 out-of-range inbound ignored");

    // disable keeps pending
    inbound(2, 0);
    busWrite('h18, id(2, 0));
    check("R4 irq low when disabled", 32'(irqOut), 0);
    busWrite('h14, id(2, 0));
    busRead('h10, id(2, 0), "R4 pending retained over disable");

    // set and clear of the same pair in one cycle
    @(negedge clk);
    inValid = 1'b1; inClient = 16'd2; inSignal = 16'd0;
    busSel = 1'b1; busWr = 1'b1; busAddr = AW'('h1C); busWdata = id(2, 0);
    @(negedge clk);
    inValid = 1'b0; busSel = 1'b0; busWr = 1'b0;
    check("R8 set wins irq", 32'(irqOut), 1);
    busRead('h10, id(2, 0), "R8 set wins over clear");

    // unmapped write
    busWrite('h20, id(2, 0));
    busWrite('h3C, id(2, 0));
    busRead('h10, id(2, 0), "R1 unmapped write ignored");

    // reset clears pending and enable
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R9 irq after second reset", 32'(irqOut), 0);
    busWrite('h14, id(2, 0));
    busRead('h10, 32'hFFFF_FFFF, "R9 pending cleared by reset");
    inbound(3, 2);
    busRead('h10, 32'hFFFF_FFFF, "R9 enable cleared by reset");

    repeat (3) @(negedge clk);
    check("R3 all reads answered", 32'(expQ.size()), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule